// File: doc/BRIEF.md
# AGC Sync Hold-off Controller

This block decides when the averaging and loop-filter stages of an automatic gain control path may take a new measurement. It accepts a synchronisation event from one of three places: the channel's oscillator sync, one of several external sync pins, or a single-cycle software strobe. A channel waking from sleep also counts as a sync. Each accepted event starts a programmable hold-off countdown. When the countdown ends, the block emits a one-cycle dump pulse. This pulse makes the averaging stage hand its current sum downstream and begin a new sum.

If the reinitialise option is enabled, the same cycle also carries a reinitialise strobe. The strobe clears the accumulator and loads fresh filter parameters. The block only issues that strobe and does not load the parameters itself. A first-event-only mode accepts one sync and ignores every later one. The latch behind that mode is cleared by reset or by a write of the control register.

Top module: `agc_sync_holdoff`

## Requirements
- R1: With `cfg_chan_sel`=1 the oscillator sync `nco_sync_i` is the hardware source and pin edges are ignored. With `cfg_chan_sel`=0 the pin chosen by `cfg_pin_sel` is the source and `nco_sync_i` is ignored.
- R2: Only the pin whose index equals `cfg_pin_sel` can start a sync. A rising edge on that pin is recognised after a two-flop synchroniser and one edge stage, so it counts two clocks later than a direct source.
- R3: A pulse on `sync_now_i` starts a sync whatever the value of `cfg_chan_sel` or `cfg_pin_sel`.
- R4: A direct-source pulse seen at edge A1 makes `dump_o` high in the cycle after edge A1+max(H,1)-1, where H is `holdoff_i`. A value of 0 or 1 therefore gives the dump after the very next edge.
- R5: `dump_o` is a single-cycle pulse for each completed countdown.
- R6: `init_o` is high together with `dump_o` exactly when `cfg_init_on_sync`=1. It is never high without `dump_o`.
- R7: A sync arriving while a countdown runs reloads the counter with H and restarts the countdown.
- R8: With `cfg_first_only`=1, once one sync has been accepted, every later sync is ignored.
- R9: A pulse on `cfg_wr_i` clears the first-sync latch, so the next sync is accepted again.
- R10: A falling edge of `sleep_i` acts as a direct-source sync.
- R11: While `rst_i` is high and in the cycle after it is released, `dump_o` and `init_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Control register written; clears the first-sync latch |
| cfg_chan_sel | input | 1 | 1: oscillator sync is the source, 0: a pin |
| cfg_pin_sel | input | 2 | Index of the sync pin used |
| cfg_init_on_sync | input | 1 | Issue reinitialise strobe with the dump |
| cfg_first_only | input | 1 | Act on the first sync only |
| holdoff_i | input | 16 | Hold-off count H |
| nco_sync_i | input | 1 | Channel oscillator sync pulse |
| sync_pins_i | input | 4 | Asynchronous sync pins |
| sync_now_i | input | 1 | Software sync strobe (one cycle) |
| sleep_i | input | 1 | Channel sleep level; falling edge syncs |
| dump_o | output | 1 | Accumulator dump pulse |
| init_o | output | 1 | Clear-and-reload strobe |

## Verification
The in-line assertions check the countdown on every cycle. They confirm that a new sync reloads the counter with H, that an idle-free count falls by one per clock, that a short hold-off fires on the next edge, and that the reinitialise strobe never appears without a dump. The end-to-end latency from each source, pin selection, the extra synchroniser delay, the rejection of unselected sources, and first-only and register-write clearing depend on sequences of stimulus. Those only the bench scenarios can show, by sweeping the hold-off over every source and pin.

// File: rtl/agc_sync_pkg.sv
`timescale 1ns/1ps
package agc_sync_pkg;
  localparam int PIN_N  = 4;
  localparam int SEL_W  = $clog2(PIN_N);
  localparam int HOLD_W = 16;

  typedef struct packed {
    logic chan_sel;
    logic init_on_sync;
    logic first_only;
  } agc_mode_t;
endpackage

// File: rtl/agc_sync_edge.sv
`timescale 1ns/1ps
module agc_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_o[g] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/agc_sync_select.sv
`timescale 1ns/1ps
module agc_sync_select #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic          chan_sel_i,
  input  logic [SW-1:0] pin_sel_i,
  input  logic [N-1:0]  rise_i,
  input  logic          nco_i,
  input  logic          now_i,
  input  logic          wake_i,
  output logic          trig_o
);
  logic hw_src;
  always_comb begin
    hw_src = chan_sel_i ? nco_i : rise_i[pin_sel_i];
    trig_o = hw_src | now_i | wake_i;
  end
endmodule

// File: rtl/agc_sync_countdown.sv
`timescale 1ns/1ps
module agc_sync_countdown #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         ev_i,
  input  logic [W-1:0] hold_i,
  input  logic         init_i,
  output logic         fire_o,
  output logic         init_o
);
  logic [W-1:0] cnt_q;
  logic         active_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      fire_o   <= 1'b0;
      init_o   <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      init_o <= 1'b0;
      if (ev_i) begin
        if (hold_i <= W'(1)) begin
          fire_o   <= 1'b1;
          init_o   <= init_i;
          active_q <= 1'b0;
        end else begin
          cnt_q    <= hold_i;
          active_q <= 1'b1;
        end
      end else if (active_q) begin
        cnt_q <= cnt_q - W'(1);
        if (cnt_q == W'(2)) begin
          fire_o   <= 1'b1;
          init_o   <= init_i;
          active_q <= 1'b0;
        end
      end
    end
  end

  // R7
  reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev_i && hold_i > W'(1)) |=> (active_q && cnt_q == $past(hold_i)));
  // R4
  short_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev_i && hold_i <= W'(1)) |=> fire_o);
  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_q && !ev_i && cnt_q != W'(2)) |=> (active_q && cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/agc_sync_holdoff.sv
`timescale 1ns/1ps
module agc_sync_holdoff
  import agc_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_chan_sel,
  input  logic [SEL_W-1:0]  cfg_pin_sel,
  input  logic              cfg_init_on_sync,
  input  logic              cfg_first_only,
  input  logic [HOLD_W-1:0] holdoff_i,
  input  logic              nco_sync_i,
  input  logic [PIN_N-1:0]  sync_pins_i,
  input  logic              sync_now_i,
  input  logic              sleep_i,
  output logic              dump_o,
  output logic              init_o
);
  agc_mode_t        mode;
  logic [PIN_N-1:0] rise;
  logic             sleep_q, wake, trig, accept, seen_q;

  assign mode = '{chan_sel: cfg_chan_sel, init_on_sync: cfg_init_on_sync,
                  first_only: cfg_first_only};

  agc_sync_edge #(.N(PIN_N)) u_edge (
    .clk_i(clk_i), .rst_i(rst_i), .pin_i(sync_pins_i), .rise_o(rise));

  always_ff @(posedge clk_i) begin
    if (rst_i) sleep_q <= 1'b0;
    else       sleep_q <= sleep_i;
  end
  assign wake = sleep_q & ~sleep_i;

  agc_sync_select #(.N(PIN_N)) u_sel (
    .chan_sel_i(mode.chan_sel), .pin_sel_i(cfg_pin_sel), .rise_i(rise),
    .nco_i(nco_sync_i), .now_i(sync_now_i), .wake_i(wake), .trig_o(trig));

  assign accept = trig & ~(mode.first_only & seen_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || cfg_wr_i) seen_q <= 1'b0;
    else if (accept)       seen_q <= 1'b1;
  end

  agc_sync_countdown #(.W(HOLD_W)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .ev_i(accept), .hold_i(holdoff_i),
    .init_i(mode.init_on_sync), .fire_o(dump_o), .init_o(init_o));

  // R6
  init_dump_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    init_o |-> dump_o);
  // R11
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!dump_o && !init_o));
endmodule

// File: tb/sim_agc_sync_holdoff.sv
`timescale 1ns/1ps
module sim_agc_sync_holdoff;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, chan_sel = 1'b1, init_on = 1'b0, first_only = 1'b0;
  logic [1:0]  pin_sel = 2'd0;
  logic [15:0] holdoff = 16'd0;
  logic        nco = 1'b0, now = 1'b0, sleep = 1'b0;
  logic [3:0]  pins = 4'd0;
  logic        dump, init;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  agc_sync_holdoff u0 (
    .clk_i(clk), .rst_i(rst), .cfg_wr_i(cfg_wr), .cfg_chan_sel(chan_sel),
    .cfg_pin_sel(pin_sel), .cfg_init_on_sync(init_on), .cfg_first_only(first_only),
    .holdoff_i(holdoff), .nco_sync_i(nco), .sync_pins_i(pins),
    .sync_now_i(now), .sleep_i(sleep), .dump_o(dump), .init_o(init));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // src: 0 oscillator sync, 1 pin, 2 software strobe, 3 sleep exit
  task automatic run(input int src, input int pin, input int h, input int lim,
                     output int k, output bit ini, output bit w2);
    k = -1; ini = 1'b0; w2 = 1'b0;
    if (src == 3) begin
      @(negedge clk); sleep = 1'b1;
      repeat (2) @(negedge clk);
    end
    @(negedge clk);
    holdoff = 16'(h);
    case (src)
      0: nco = 1'b1;
      1: pins[pin] = 1'b1;
      2: now = 1'b1;
      default: sleep = 1'b0;
    endcase
    for (int c = 1; c <= lim; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == 1) begin nco = 1'b0; now = 1'b0; end
      if (c == 2) pins = 4'd0;
      if (dump) begin
        k = c; ini = init;
        @(posedge clk); @(negedge clk);
        w2 = dump;
        break;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_cfg();
    @(negedge clk); cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int k, exp;
    bit ini, w2;
    repeat (3) @(negedge clk);
    chk(dump == 1'b0 && init == 1'b0, "R11 reset dump/init", int'({dump, init}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dump == 1'b0 && init == 1'b0, "R11 after release", int'({dump, init}), 0);

    // R4 R5 R6 R10 R3 R1 R2: latency sweep across sources and hold-off values
    for (int src = 0; src < 4; src++) begin
      for (int h = 0; h <= 7; h++) begin
        int hv;
        hv = (h == 7) ? 40 : h;
        chan_sel = (src == 0);
        pin_sel  = 2'(h % 4);
        init_on  = h[0];
        run(src, h % 4, hv, 80, k, ini, w2);
        exp = ((hv < 1) ? 1 : hv) + ((src == 1) ? 2 : 0);
        chk(k == exp, (src == 1) ? "R2 pin latency" : (src == 2) ? "R3 sync-now latency" :
            (src == 3) ? "R10 wake latency" : "R4 hold-off latency", k, exp);
        chk(ini == h[0], "R6 init with dump", int'(ini), h);
        chk(w2 == 1'b0, "R5 single-cycle dump", int'(w2), 0);
      end
    end
    init_on = 1'b0;

    // R3 software strobe with oscillator selected
    chan_sel = 1'b1;
    run(2, 0, 5, 40, k, ini, w2);
    chk(k == 5, "R3 sync-now with chan_sel=1", k, 5);

    // R1 pin ignored when oscillator selected; oscillator ignored when pin selected
    for (int p = 0; p < 4; p++) begin
      chan_sel = 1'b1; pin_sel = 2'(p);
      run(1, p, 2, 30, k, ini, w2);
      chk(k == -1, "R1 pin ignored when chan_sel=1", k, -1);
    end
    chan_sel = 1'b0; pin_sel = 2'd0;
    run(0, 0, 2, 30, k, ini, w2);
    chk(k == -1, "R1 oscillator ignored when chan_sel=0", k, -1);

    // R2 unselected pins ignored
    for (int p = 0; p < 4; p++) begin
      pin_sel = 2'((p + 1) % 4);
      run(1, p, 2, 30, k, ini, w2);
      chk(k == -1, "R2 unselected pin ignored", k, -1);
    end

    // R7 retrigger during countdown
    chan_sel = 1'b1;
    run(0, 0, 10, 4, k, ini, w2);
    chk(k == -1, "R7 no dump before retrigger", k, -1);
    run(0, 0, 10, 30, k, ini, w2);
    chk(k == 10, "R7 countdown restarted", k, 10);

    // R8 first-only, R9 register write clears latch
    first_only = 1'b1;
    wr_cfg();
    run(0, 0, 2, 30, k, ini, w2);
    chk(k == 2, "R8 first sync accepted", k, 2);
    run(0, 0, 2, 30, k, ini, w2);
    chk(k == -1, "R8 second sync ignored", k, -1);
    run(2, 0, 2, 30, k, ini, w2);
    chk(k == -1, "R8 sync-now ignored after first", k, -1);
    wr_cfg();
    run(0, 0, 3, 30, k, ini, w2);
    chk(k == 3, "R9 latch cleared by write", k, 3);
    first_only = 1'b0;
    run(0, 0, 3, 30, k, ini, w2);
    chk(k == 3, "R8 mode off accepts again", k, 3);

    finish_up();
  end
endmodule